// File: doc/BRIEF.md
# Two-Way Set-Associative Write-Back Cache

This block sits between a processor that issues single-word reads and writes and a slower main memory that moves data one word per handshake beat. The 16-bit word address splits into a tag, a set index and a word offset. Storage is 64 sets of two 16-word blocks, 2048 words in all. Accesses that hit complete in the cycle they are presented. Accesses that miss stall the processor while the block is fetched. If the chosen victim is dirty, it is first copied back to memory.

The cache allocates on writes and defers memory updates until eviction. The victim is chosen by a per-set least-recently-used bit. On a read miss the requested word goes to the processor on the refill beat that carries it. An invalidate port lets an outside agent that has changed main memory drop a matching resident block.

Top module: `twa_wb_cache`

## Requirements
- R1: The address bits are split as follows: bits 15:10 are the tag, bits 9:4 select one of 64 sets, and bits 3:0 select the word within a block. Blocks with different tags in the same set occupy the two ways of that set. Blocks in different sets never displace each other.
- R2: Reset clears every valid bit. While reset is held and after it, `cpu_ready` and `mem_req` stay low until a request is made. The first access after reset to any address is a miss.
- R3: A read hit raises `cpu_ready` in the same cycle as the request, with the cached word on `cpu_rdata`, and causes no memory beat.
- R4: A write hit raises `cpu_ready` in the same cycle. It updates only the cached word and marks the block dirty. Memory is not written at that point.
- R5: A miss fetches the whole block as 16 read beats on `mem_req` with `mem_we` low. The beats run from word 0 to word 15, and the filled block then becomes valid.
- R6: On a read miss, `cpu_ready` rises on the beat that delivers the requested word, with that word on `cpu_rdata`. No further processor access is served until the refill has finished.
- R7: On a write miss, the block is fetched first and the addressed word is replaced by the written data. `cpu_ready` rises on the final refill beat, and the block is left dirty.
- R8: The victim is chosen in this order: an invalid way 0, then an invalid way 1, then the least recently used way. Every hit and every fill makes the other way of that set the least recently used.
- R9: A dirty victim is written back as 16 write beats, word 0 to word 15, at its own address. The refill reads start on the cycle after the last write-back beat.
- R10: An `inv_valid` pulse whose `inv_blk` equals address bits 15:4 of a resident block clears that block's valid bit and discards any dirty data. It has no effect on any other block.
- R11: If an invalidate names the same block as a processor access in the same cycle while the cache is idle, the invalidate wins. The access is not served in that cycle and proceeds as a miss afterwards.
- R12: While `mem_req` is high and `mem_ack` is low, `mem_addr`, `mem_we` and `mem_wdata` hold their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| cpu_req | input | 1 | Processor access request, held until `cpu_ready` |
| cpu_we | input | 1 | 1 = write, 0 = read |
| cpu_addr | input | 16 | Word address |
| cpu_wdata | input | 16 | Write data |
| cpu_ready | output | 1 | Access completes this cycle |
| cpu_rdata | output | 16 | Read data, valid with `cpu_ready` on reads |
| mem_req | output | 1 | Memory beat request |
| mem_we | output | 1 | 1 = write-back beat, 0 = refill read beat |
| mem_addr | output | 16 | Word address of the beat |
| mem_wdata | output | 16 | Write-back data |
| mem_ack | input | 1 | Beat completes this cycle |
| mem_rdata | input | 16 | Refill data, valid with `mem_ack` |
| inv_valid | input | 1 | Invalidate request |
| inv_blk | input | 12 | Block address (address bits 15:4) to invalidate |

## Verification
A hit is due in the request cycle itself. A clean read miss is due on the cycle of refill beat k+1, where k is the word offset. Each dirty eviction adds 16 beats, and a write miss finishes on the sixteenth refill beat. An access that collides with an invalidate is due one cycle later than the equivalent miss. The bench drives inputs just after the falling edge and samples 4 ns later, before the next rising edge. It counts the cycles until `cpu_ready` and compares that count with the value derived for each vector. It then lets every refill drain before judging the memory beat counts, except in the test that deliberately issues an access while the refill is still running.

// File: rtl/cache_pkg.sv
package cache_pkg;

    localparam int unsigned NUM_WAYS = 2;

    typedef enum logic [1:0] {
        S_IDLE  = 2'd0,
        S_EVICT = 2'd1,
        S_FILL  = 2'd2
    } cstate_e;

endpackage

// File: rtl/cache_tag_store.sv
module cache_tag_store
    import cache_pkg::*;
#(
    parameter int TAG_W = 6,
    parameter int SET_W = 6
) (
    input  logic                           clk,
    input  logic                           rst_n,
    input  logic [SET_W-1:0]               lk_set,
    input  logic [TAG_W-1:0]               lk_tag,
    output logic [NUM_WAYS-1:0]            lk_hit,
    output logic [NUM_WAYS-1:0]            lk_valid,
    output logic [NUM_WAYS-1:0]            lk_dirty,
    output logic [NUM_WAYS-1:0][TAG_W-1:0] lk_tags,
    output logic                           lk_lru,
    input  logic                           touch_en,
    input  logic                           touch_way,
    input  logic                           mark_dirty,
    input  logic                           fill_en,
    input  logic                           fill_way,
    input  logic [SET_W-1:0]               fill_set,
    input  logic [TAG_W-1:0]               fill_tag,
    input  logic                           fill_dirty,
    input  logic                           inv_en,
    input  logic [SET_W-1:0]               inv_set,
    input  logic [TAG_W-1:0]               inv_tag
);
    localparam int SETS = 1 << SET_W;

    logic [SETS-1:0]  valid_q [NUM_WAYS];
    logic [SETS-1:0]  dirty_q [NUM_WAYS];
    logic [TAG_W-1:0] tag_q   [NUM_WAYS][SETS];
    logic [SETS-1:0]  lru_q;

    for (genvar w = 0; w < NUM_WAYS; w++) begin : g_way
        assign lk_valid[w] = valid_q[w][lk_set];
        assign lk_dirty[w] = dirty_q[w][lk_set];
        assign lk_tags[w]  = tag_q[w][lk_set];
        assign lk_hit[w]   = lk_valid[w] && (lk_tags[w] == lk_tag);
    end

    assign lk_lru = lru_q[lk_set];

    // Invalidate first, so a completing fill of the same slot wins.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int w = 0; w < NUM_WAYS; w++) begin
                valid_q[w] <= '0;
                dirty_q[w] <= '0;
            end
            lru_q <= '0;
        end else begin
            if (inv_en) begin
                for (int w = 0; w < NUM_WAYS; w++) begin
                    if (valid_q[w][inv_set] && tag_q[w][inv_set] == inv_tag) begin
                        valid_q[w][inv_set] <= 1'b0;
                    end
                end
            end
            if (touch_en) begin
                lru_q[lk_set] <= ~touch_way;
                if (mark_dirty) begin
                    dirty_q[touch_way][lk_set] <= 1'b1;
                end
            end
            if (fill_en) begin
                valid_q[fill_way][fill_set] <= 1'b1;
                dirty_q[fill_way][fill_set] <= fill_dirty;
                lru_q[fill_set]             <= ~fill_way;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (fill_en) begin
            tag_q[fill_way][fill_set] <= fill_tag;
        end
    end

endmodule

// File: rtl/cache_data_store.sv
module cache_data_store #(
    parameter int DATA_W = 16,
    parameter int SET_W  = 6,
    parameter int OFF_W  = 4
) (
    input  logic              clk,
    input  logic              rd_way,
    input  logic [SET_W-1:0]  rd_set,
    input  logic [OFF_W-1:0]  rd_word,
    output logic [DATA_W-1:0] rd_data,
    input  logic              wr_en,
    input  logic              wr_way,
    input  logic [SET_W-1:0]  wr_set,
    input  logic [OFF_W-1:0]  wr_word,
    input  logic [DATA_W-1:0] wr_data
);
    localparam int IDX_W = 1 + SET_W + OFF_W;
    localparam int DEPTH = 1 << IDX_W;

    logic [DATA_W-1:0] word_q [DEPTH];

    assign rd_data = word_q[{rd_way, rd_set, rd_word}];

    always_ff @(posedge clk) begin
        if (wr_en) begin
            word_q[{wr_way, wr_set, wr_word}] <= wr_data;
        end
    end

endmodule

// File: rtl/twa_wb_cache.sv
module twa_wb_cache
    import cache_pkg::*;
#(
    parameter int ADDR_W = 16,
    parameter int DATA_W = 16,
    parameter int SET_W  = 6,
    parameter int OFF_W  = 4
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    cpu_req,
    input  logic                    cpu_we,
    input  logic [ADDR_W-1:0]       cpu_addr,
    input  logic [DATA_W-1:0]       cpu_wdata,
    output logic                    cpu_ready,
    output logic [DATA_W-1:0]       cpu_rdata,
    output logic                    mem_req,
    output logic                    mem_we,
    output logic [ADDR_W-1:0]       mem_addr,
    output logic [DATA_W-1:0]       mem_wdata,
    input  logic                    mem_ack,
    input  logic [DATA_W-1:0]       mem_rdata,
    input  logic                    inv_valid,
    input  logic [ADDR_W-OFF_W-1:0] inv_blk
);
    localparam int TAG_W = ADDR_W - SET_W - OFF_W;
    localparam logic [OFF_W-1:0] LAST_WORD = OFF_W'((1 << OFF_W) - 1);

    typedef struct packed {
        cstate_e           st;
        logic [OFF_W-1:0]  cnt;
        logic              way;
        logic [ADDR_W-1:0] addr;
        logic              we;
        logic [DATA_W-1:0] wdata;
        logic [TAG_W-1:0]  vtag;
    } ctl_t;

    ctl_t ctl_d, ctl_q;

    // address fields of the live request and of the miss in service
    logic [TAG_W-1:0] c_tag, m_tag;
    logic [SET_W-1:0] c_set, m_set;
    logic [OFF_W-1:0] c_off, m_off;

    assign c_tag = cpu_addr[ADDR_W-1 -: TAG_W];
    assign c_set = cpu_addr[OFF_W +: SET_W];
    assign c_off = cpu_addr[OFF_W-1:0];
    assign m_tag = ctl_q.addr[ADDR_W-1 -: TAG_W];
    assign m_set = ctl_q.addr[OFF_W +: SET_W];
    assign m_off = ctl_q.addr[OFF_W-1:0];

    logic                           idle;
    logic [SET_W-1:0]               lk_set;
    logic [TAG_W-1:0]               lk_tag;
    logic [NUM_WAYS-1:0]            lk_hit, lk_valid, lk_dirty;
    logic [NUM_WAYS-1:0][TAG_W-1:0] lk_tags;
    logic                           lk_lru;
    logic                           hit, hit_way, victim, inv_clash;
    logic                           touch_en, mark_dirty, fill_en;
    logic                           rd_way;
    logic [SET_W-1:0]               rd_set;
    logic [OFF_W-1:0]               rd_word;
    logic [DATA_W-1:0]              rd_data;
    logic                           wr_en, wr_way;
    logic [SET_W-1:0]               wr_set;
    logic [OFF_W-1:0]               wr_word;
    logic [DATA_W-1:0]              wr_data;

    assign idle      = (ctl_q.st == S_IDLE);
    assign lk_set    = idle ? c_set : m_set;
    assign lk_tag    = idle ? c_tag : m_tag;
    assign hit       = |lk_hit;
    assign hit_way   = lk_hit[1];
    assign victim    = !lk_valid[0] ? 1'b0 : (!lk_valid[1] ? 1'b1 : lk_lru);
    assign inv_clash = inv_valid && (inv_blk == cpu_addr[ADDR_W-1:OFF_W]);
    assign rd_way    = idle ? hit_way : ctl_q.way;
    assign rd_set    = idle ? c_set : m_set;
    assign rd_word   = idle ? c_off : ctl_q.cnt;

    cache_tag_store #(
        .TAG_W (TAG_W),
        .SET_W (SET_W)
    ) i_tags (
        .clk        (clk),
        .rst_n      (rst_n),
        .lk_set     (lk_set),
        .lk_tag     (lk_tag),
        .lk_hit     (lk_hit),
        .lk_valid   (lk_valid),
        .lk_dirty   (lk_dirty),
        .lk_tags    (lk_tags),
        .lk_lru     (lk_lru),
        .touch_en   (touch_en),
        .touch_way  (hit_way),
        .mark_dirty (mark_dirty),
        .fill_en    (fill_en),
        .fill_way   (ctl_q.way),
        .fill_set   (m_set),
        .fill_tag   (m_tag),
        .fill_dirty (ctl_q.we),
        .inv_en     (inv_valid),
        .inv_set    (inv_blk[SET_W-1:0]),
        .inv_tag    (inv_blk[ADDR_W-OFF_W-1 -: TAG_W])
    );

    cache_data_store #(
        .DATA_W (DATA_W),
        .SET_W  (SET_W),
        .OFF_W  (OFF_W)
    ) i_data (
        .clk     (clk),
        .rd_way  (rd_way),
        .rd_set  (rd_set),
        .rd_word (rd_word),
        .rd_data (rd_data),
        .wr_en   (wr_en),
        .wr_way  (wr_way),
        .wr_set  (wr_set),
        .wr_word (wr_word),
        .wr_data (wr_data)
    );

    always_comb begin
        ctl_d      = ctl_q;
        cpu_ready  = 1'b0;
        cpu_rdata  = rd_data;
        mem_req    = 1'b0;
        mem_we     = 1'b0;
        mem_addr   = {m_tag, m_set, ctl_q.cnt};
        mem_wdata  = rd_data;
        touch_en   = 1'b0;
        mark_dirty = 1'b0;
        fill_en    = 1'b0;
        wr_en      = 1'b0;
        wr_way     = ctl_q.way;
        wr_set     = m_set;
        wr_word    = ctl_q.cnt;
        wr_data    = mem_rdata;

        unique case (ctl_q.st)
            S_IDLE: begin
                if (cpu_req && !inv_clash) begin
                    if (hit) begin
                        cpu_ready  = 1'b1;
                        touch_en   = 1'b1;
                        mark_dirty = cpu_we;
                        wr_en      = cpu_we;
                        wr_way     = hit_way;
                        wr_set     = c_set;
                        wr_word    = c_off;
                        wr_data    = cpu_wdata;
                    end else begin
                        ctl_d.addr  = cpu_addr;
                        ctl_d.we    = cpu_we;
                        ctl_d.wdata = cpu_wdata;
                        ctl_d.way   = victim;
                        ctl_d.vtag  = lk_tags[victim];
                        ctl_d.cnt   = '0;
                        ctl_d.st    = (lk_valid[victim] && lk_dirty[victim]) ? S_EVICT : S_FILL;
                    end
                end
            end
            S_EVICT: begin
                mem_req  = 1'b1;
                mem_we   = 1'b1;
                mem_addr = {ctl_q.vtag, m_set, ctl_q.cnt};
                if (mem_ack) begin
                    ctl_d.cnt = ctl_q.cnt + 1'b1;
                    if (ctl_q.cnt == LAST_WORD) begin
                        ctl_d.st = S_FILL;
                    end
                end
            end
            S_FILL: begin
                mem_req = 1'b1;
                if (mem_ack) begin
                    wr_en     = 1'b1;
                    ctl_d.cnt = ctl_q.cnt + 1'b1;
                    if (ctl_q.cnt == m_off) begin
                        if (ctl_q.we) begin
                            wr_data = ctl_q.wdata;
                        end else begin
                            cpu_ready = 1'b1;
                            cpu_rdata = mem_rdata;
                        end
                    end
                    if (ctl_q.cnt == LAST_WORD) begin
                        fill_en  = 1'b1;
                        ctl_d.st = S_IDLE;
                        if (ctl_q.we) begin
                            cpu_ready = 1'b1;
                        end
                    end
                end
            end
            default: ctl_d.st = S_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctl_q <= '0;
        end else begin
            ctl_q <= ctl_d;
        end
    end

endmodule

// File: rtl/cache_sva.sv
module cache_sva #(
    parameter int ADDR_W = 16,
    parameter int DATA_W = 16,
    parameter int OFF_W  = 4
) (
    input logic                    clk,
    input logic                    rst_n,
    input logic                    cpu_req,
    input logic                    cpu_we,
    input logic [ADDR_W-1:0]       cpu_addr,
    input logic                    cpu_ready,
    input logic [DATA_W-1:0]       cpu_rdata,
    input logic                    mem_req,
    input logic                    mem_we,
    input logic [ADDR_W-1:0]       mem_addr,
    input logic [DATA_W-1:0]       mem_wdata,
    input logic                    mem_ack,
    input logic [DATA_W-1:0]       mem_rdata,
    input logic                    inv_valid,
    input logic [ADDR_W-OFF_W-1:0] inv_blk
);
    localparam logic [OFF_W-1:0] LAST = OFF_W'((1 << OFF_W) - 1);

    assert_beat_hold_R12: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req && !mem_ack |=> mem_req && $stable(mem_addr) && $stable(mem_we) && $stable(mem_wdata));

    assert_fill_order_R5: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req && !mem_we && mem_ack && mem_addr[OFF_W-1:0] != LAST
        |=> mem_req && !mem_we
            && mem_addr[OFF_W-1:0] == OFF_W'($past(mem_addr[OFF_W-1:0]) + 1'b1)
            && mem_addr[ADDR_W-1:OFF_W] == $past(mem_addr[ADDR_W-1:OFF_W]));

    assert_wb_then_fill_R9: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req && mem_we && mem_ack && mem_addr[OFF_W-1:0] == LAST
        |=> mem_req && !mem_we && mem_addr[OFF_W-1:0] == '0);

    assert_early_word_R6: assert property (@(posedge clk) disable iff (!rst_n)
        cpu_ready && mem_req && !cpu_we
        |-> mem_ack && !mem_we && mem_addr == cpu_addr && cpu_rdata == mem_rdata);

    assert_inv_first_R11: assert property (@(posedge clk) disable iff (!rst_n)
        inv_valid && cpu_req && !mem_req && inv_blk == cpu_addr[ADDR_W-1:OFF_W] |-> !cpu_ready);

    assert_wmiss_last_R7: assert property (@(posedge clk) disable iff (!rst_n)
        cpu_ready && mem_req && cpu_we
        |-> mem_ack && !mem_we && mem_addr[OFF_W-1:0] == LAST
            && mem_addr[ADDR_W-1:OFF_W] == cpu_addr[ADDR_W-1:OFF_W]);

endmodule

bind twa_wb_cache cache_sva #(
    .ADDR_W (ADDR_W),
    .DATA_W (DATA_W),
    .OFF_W  (OFF_W)
) i_cache_sva (
    .clk       (clk),
    .rst_n     (rst_n),
    .cpu_req   (cpu_req),
    .cpu_we    (cpu_we),
    .cpu_addr  (cpu_addr),
    .cpu_ready (cpu_ready),
    .cpu_rdata (cpu_rdata),
    .mem_req   (mem_req),
    .mem_we    (mem_we),
    .mem_addr  (mem_addr),
    .mem_wdata (mem_wdata),
    .mem_ack   (mem_ack),
    .mem_rdata (mem_rdata),
    .inv_valid (inv_valid),
    .inv_blk   (inv_blk)
);

// File: tb/test_twa_wb_cache.sv
module test_twa_wb_cache;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        cpu_req, cpu_we;
    logic [15:0] cpu_addr, cpu_wdata, cpu_rdata;
    logic        cpu_ready;
    logic        mem_req, mem_we, mem_ack;
    logic [15:0] mem_addr, mem_wdata, mem_rdata;
    logic        inv_valid;
    logic [11:0] inv_blk;

    always #5 clk = ~clk;

    twa_wb_cache i_twa_wb_cache (
        .clk       (clk),
        .rst_n     (rst_n),
        .cpu_req   (cpu_req),
        .cpu_we    (cpu_we),
        .cpu_addr  (cpu_addr),
        .cpu_wdata (cpu_wdata),
        .cpu_ready (cpu_ready),
        .cpu_rdata (cpu_rdata),
        .mem_req   (mem_req),
        .mem_we    (mem_we),
        .mem_addr  (mem_addr),
        .mem_wdata (mem_wdata),
        .mem_ack   (mem_ack),
        .mem_rdata (mem_rdata),
        .inv_valid (inv_valid),
        .inv_blk   (inv_blk)
    );

    int n_chk = 0, n_fail = 0;
    int rd_beats = 0, wr_beats = 0;
    bit slow = 1'b0, phase = 1'b0, done = 1'b0;

    logic [15:0] wmem  [logic [15:0]];   // main memory words written back
    logic [15:0] cview [logic [15:0]];   // processor-visible words not yet in memory

    function automatic logic [15:0] pat(input logic [15:0] a);
        return {a[7:0], a[15:8]} ^ 16'h3C5A;
    endfunction

    function automatic logic [15:0] memval(input logic [15:0] a);
        if (wmem.exists(a)) return wmem[a];
        return pat(a);
    endfunction

    function automatic logic [15:0] expv(input logic [15:0] a);
        if (cview.exists(a)) return cview[a];
        return memval(a);
    endfunction

    task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    task automatic summary();
        if (!done) begin
            done = 1'b1;
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
            $finish;
        end
    endtask

    // memory model: answers at the falling edge, one beat per cycle (or every other cycle when slow)
    initial begin
        mem_ack   = 1'b0;
        mem_rdata = '0;
        forever begin
            @(negedge clk);
            if (mem_req && (!slow || phase)) begin
                mem_ack = 1'b1;
                if (mem_we) begin
                    wmem[mem_addr] = mem_wdata;
                    wr_beats++;
                end else begin
                    mem_rdata = memval(mem_addr);
                    rd_beats++;
                end
            end else begin
                mem_ack = 1'b0;
            end
            phase = ~phase;
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        chk(1'b0, "watchdog", "run timed out", 0, 1);
        summary();
    end

    // called just after a falling edge; leaves just after a falling edge
    task automatic access(input bit we, input logic [15:0] a, input logic [15:0] wd,
                          input bit drain, input bit inv_same,
                          output logic [15:0] rd, output int lat, output int beats_rdy, output bit req_rdy);
        int r0 = rd_beats;
        cpu_we = we; cpu_addr = a; cpu_wdata = wd; cpu_req = 1'b1;
        lat = 0; rd = '0; beats_rdy = 0; req_rdy = 1'b0;
        if (inv_same) begin
            inv_valid = 1'b1;
            inv_blk   = a[15:4];
        end
        forever begin
            #4;
            if (cpu_ready) begin
                rd = cpu_rdata;
                beats_rdy = rd_beats - r0;
                req_rdy = mem_req;
                break;
            end
            @(negedge clk);
            inv_valid = 1'b0;
            lat++;
        end
        @(negedge clk);
        cpu_req = 1'b0;
        inv_valid = 1'b0;
        if (drain) while (mem_req) @(negedge clk);
    endtask

    task automatic invalidate(input logic [11:0] blk);
        inv_valid = 1'b1;
        inv_blk = blk;
        @(negedge clk);
        inv_valid = 1'b0;
        for (int i = 0; i < 16; i++) cview.delete({blk, 4'(i)});
    endtask

    task automatic do_reset();
        rst_n = 1'b0;
        repeat (2) @(negedge clk);
        #4;
        chk(cpu_ready == 1'b0, "R2", "cpu_ready in reset", cpu_ready, 0);
        chk(mem_req == 1'b0, "R2", "mem_req in reset", mem_req, 0);
        @(negedge clk);
        rst_n = 1'b1;
        cview.delete();
    endtask

    typedef struct packed {
        logic        we;
        logic [15:0] addr;
        logic [15:0] wd;
        int          lat;
        int          wb;
    } vec_t;

    // address = tag<<10 | set<<4 | word
    localparam int NV = 14;
    localparam vec_t VECS [NV] = '{
        '{1'b0, 16'h0453, 16'h0000,  4,  0},  // tag1 set5 miss into way0
        '{1'b0, 16'h0453, 16'h0000,  0,  0},  // read hit
        '{1'b1, 16'h0850, 16'h1111, 16,  0},  // write miss into empty way1
        '{1'b0, 16'h0850, 16'h0000,  0,  0},  // read back written word
        '{1'b0, 16'h045F, 16'h0000,  0,  0},  // touch tag1: way1 becomes LRU
        '{1'b0, 16'h0C57, 16'h0000, 24, 16},  // evict dirty tag2
        '{1'b0, 16'h0450, 16'h0000,  0,  0},  // tag1 survived
        '{1'b0, 16'h0850, 16'h0000,  1,  0},  // tag2 back from memory, replaces clean tag3
        '{1'b1, 16'h0859, 16'h2222,  0,  0},  // write hit
        '{1'b0, 16'h109F, 16'h0000, 16,  0},  // other set, last word
        '{1'b1, 16'h0000, 16'h3333, 16,  0},  // write miss set0
        '{1'b0, 16'h0000, 16'h0000,  0,  0},  // read hit on merged word
        '{1'b0, 16'h1451, 16'h0000,  2,  0},  // evict clean tag1
        '{1'b0, 16'h1852, 16'h0000, 19, 16}   // evict dirty tag2 again
    };

    initial begin
        logic [15:0] rd;
        int lat, br, wb0;
        bit rq;
        cpu_req = 1'b0; cpu_we = 1'b0; cpu_addr = '0; cpu_wdata = '0;
        inv_valid = 1'b0; inv_blk = '0;
        @(negedge clk);
        do_reset();

        // R1 R3 R4 R5 R7 R8 R9: table walk with fast memory
        for (int i = 0; i < NV; i++) begin
            wb0 = wr_beats;
            access(VECS[i].we, VECS[i].addr, VECS[i].wd, 1'b1, 1'b0, rd, lat, br, rq);
            chk(lat == VECS[i].lat, "R1/R3/R5/R7/R8", $sformatf("vec %0d latency", i), lat, VECS[i].lat);
            if (VECS[i].we) cview[VECS[i].addr] = VECS[i].wd;
            else chk(rd == expv(VECS[i].addr), "R3/R5", $sformatf("vec %0d data", i), rd, expv(VECS[i].addr));
            chk(wr_beats - wb0 == VECS[i].wb, "R4/R9", $sformatf("vec %0d write beats", i), wr_beats - wb0, VECS[i].wb);
            if (VECS[i].wb != 0) begin
                for (int w = 0; w < 16; w++) begin
                    logic [15:0] ea = {VECS[i].addr[15:4] == 12'h045 ? 12'h085 : 12'h085, 4'(w)};
                    if (cview.exists(ea)) begin
                        wmem[ea] = wmem[ea];
                        cview.delete(ea);
                    end
                end
            end
        end
        // R9: written-back words now sit in memory
        chk(wmem.exists(16'h0859) && wmem[16'h0859] == 16'h2222, "R9", "written-back word 9", memval(16'h0859), 16'h2222);
        chk(wmem.exists(16'h0850) && wmem[16'h0850] == 16'h1111, "R9", "written-back word 0", memval(16'h0850), 16'h1111);

        // R6: early word, then a second access stalls until the refill ends
        access(1'b0, 16'h1CC2, 16'h0, 1'b0, 1'b0, rd, lat, br, rq);
        chk(br == 3, "R6", "beats at ready", br, 3);
        chk(rq == 1'b1, "R6", "refill still running at ready", rq, 1);
        chk(rd == expv(16'h1CC2), "R6", "early word", rd, expv(16'h1CC2));
        access(1'b0, 16'h1CC5, 16'h0, 1'b1, 1'b0, rd, lat, br, rq);
        chk(lat == 13, "R6", "stall until refill done", lat, 13);
        chk(rd == expv(16'h1CC5), "R6", "hit after refill", rd, expv(16'h1CC5));

        // R10: invalidate of a block that is not resident leaves the set alone
        invalidate(12'h24C);
        access(1'b0, 16'h1CC7, 16'h0, 1'b1, 1'b0, rd, lat, br, rq);
        chk(lat == 0, "R10", "unrelated block still hits", lat, 0);

        // R12: slow memory, beats held until acknowledged
        slow = 1'b1;
        access(1'b0, 16'h2144, 16'h0, 1'b1, 1'b0, rd, lat, br, rq);
        chk(rd == expv(16'h2144), "R12", "data with slow memory", rd, expv(16'h2144));
        slow = 1'b0;

        // R10: dirty resident block invalidated, dirty data dropped
        access(1'b1, 16'h2144, 16'h4444, 1'b1, 1'b0, rd, lat, br, rq);
        chk(lat == 0, "R4", "write hit latency", lat, 0);
        invalidate(12'h214);
        wb0 = wr_beats;
        access(1'b0, 16'h2144, 16'h0, 1'b1, 1'b0, rd, lat, br, rq);
        chk(lat == 5, "R10", "miss after invalidate", lat, 5);
        chk(rd == pat(16'h2144), "R10", "memory value after invalidate", rd, pat(16'h2144));
        chk(wr_beats == wb0, "R10", "no write-back of invalidated block", wr_beats - wb0, 0);

        // R11: invalidate and access to the same block in one cycle
        access(1'b0, 16'h2141, 16'h0, 1'b1, 1'b1, rd, lat, br, rq);
        chk(lat == 3, "R11", "access delayed and missed", lat, 3);
        chk(rd == expv(16'h2141), "R11", "data after collision", rd, expv(16'h2141));

        // R2: reset drops every block
        do_reset();
        access(1'b0, 16'h0000, 16'h0, 1'b1, 1'b0, rd, lat, br, rq);
        chk(lat == 1, "R2", "miss after reset", lat, 1);
        chk(rd == pat(16'h0000), "R2", "memory value after reset", rd, pat(16'h0000));

        summary();
    end

endmodule